// File: doc/BRIEF.md
# I/Q Sample Port Demultiplexer

This block sits at the input of a dual-channel converter datapath. It takes 12-bit sample words from the input pins and turns them into aligned in-phase/quadrature pairs in two's complement. Each pair comes with a one-cycle valid strobe. The input pins can be wired in two ways, and a mode input picks between them.

In two-lane mode, each lane carries its own channel. The wide lane carries I. The Q word is built from three sources: a narrow lane for its low bits, plus the channel-tag pin and the alternate-clock pin, which become Q bits 11 and 10. In interleaved mode, only the wide lane carries data. The channel-tag pin then marks each word as I or Q. The block holds the latest I word and pairs it with the next Q word.

A configuration input chooses which clock edge samples the pins. Another chooses whether the incoming words are offset binary or two's complement. All configuration inputs are plain static levels. They are expected to change only while reset is held.

Top module: `iq_port_demux`

## Requirements
- R1: With `cfg_interleave`=0, every captured word produces a pair. The pair is `out_i` = wide lane and `out_q` = {`tag_pin`, `alt_pin`, `lane_b`}, bit 11 down to bit 0, with `out_valid` high.
- R2: With `cfg_interleave`=1, only the wide lane supplies data. A word captured with `tag_pin`=1 is an I word and one with `tag_pin`=0 is a Q word. `lane_b` and `alt_pin` have no effect.
- R3: In interleaved mode, a Q word captured while an I word is held produces a pair: the held I and this Q. The held I is used up, so a second Q word does not pair with it.
- R4: In interleaved mode, an I word captured while another I word is held replaces it. The next pair carries the newer I.
- R5: In interleaved mode, a Q word captured with no I word held produces no pair.
- R6: With `cfg_fall_edge`=0, the pins are sampled at a rising clock edge. With `cfg_fall_edge`=1, they are sampled at the falling edge just before it. In both cases the resulting pair appears on the outputs after the next rising edge.
- R7: With `cfg_offset_bin`=1, bit 11 of every data word is inverted to give two's complement. With `cfg_offset_bin`=0, words pass through unchanged. The channel tag is never converted.
- R8: In any cycle without a new pair, `out_valid` is low and `out_i`/`out_q` keep their last values.
- R9: While `rst_n` is low, `out_i`, `out_q` and `out_valid` are zero. Release of reset is synchronized over two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_interleave | input | 1 | 1: single shared lane with channel tag; 0: two lanes |
| cfg_fall_edge | input | 1 | 1: sample pins on falling edge |
| cfg_offset_bin | input | 1 | 1: input words are offset binary |
| lane_a | input | 12 | Wide data lane |
| lane_b | input | 10 | Narrow lane, Q bits 9..0 in two-lane mode |
| tag_pin | input | 1 | Channel tag (interleaved) or Q bit 11 |
| alt_pin | input | 1 | Q bit 10 in two-lane mode |
| out_i | output | 12 | In-phase sample, two's complement |
| out_q | output | 12 | Quadrature sample, two's complement |
| out_valid | output | 1 | One-cycle strobe for a new pair |

## Verification
The hardest situation to bring about is proving the falling-edge path really samples at the falling edge. If the pins stayed steady for a whole cycle, either edge would give the same result. So the stimulus drives the intended word only during the half-cycle around the selected edge, and the bitwise inverse during the other half. Any mix-up of edges then shows up as inverted data.

In interleaved mode, the channel-tag sequence is chosen to contain runs of I words and runs of Q words. This covers both the overwrite of a held I word and the case of a Q word arriving with nothing held.

// File: rtl/iq_demux_pkg.sv
package iq_demux_pkg;
  parameter int IQ_DW = 12;
  localparam int IQ_LANES = 2;

  typedef enum logic {
    LANE_I = 1'b0,
    LANE_Q = 1'b1
  } lane_e;
endpackage

// File: rtl/iq_edge_capture.sv
module iq_edge_capture #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_fall_edge,
  input  logic [W-1:0] pins,
  output logic [W-1:0] cap_word,
  output logic         cap_vld
);
  logic [W-1:0] neg_q;
  logic [W-1:0] cap_d;

  // Half-cycle stage on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= '0;
    else        neg_q <= pins;
  end

  always_comb begin
    cap_d = cfg_fall_edge ? neg_q : pins;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_word <= '0;
      cap_vld  <= 1'b0;
    end else begin
      cap_word <= cap_d;
      cap_vld  <= 1'b1;
    end
  end
endmodule

// File: rtl/iq_fmt_lane.sv
module iq_fmt_lane #(
  parameter int DW = 12
) (
  input  logic          cfg_offset_bin,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  always_comb begin
    dout = {din[DW-1] ^ cfg_offset_bin, din[DW-2:0]};
  end
endmodule

// File: rtl/iq_pair_assembler.sv
module iq_pair_assembler #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_interleave,
  input  logic          cap_vld,
  input  logic          tag_is_i,
  input  logic [DW-1:0] word_a,
  input  logic [DW-1:0] word_b,
  output logic [DW-1:0] out_i,
  output logic [DW-1:0] out_q,
  output logic          out_valid
);
  logic [DW-1:0] hold_q, hold_d;
  logic          have_q, have_d;
  logic [DW-1:0] i_d, q_d;
  logic          vld_d;
  logic          ld_out, ld_hold;

  always_comb begin
    vld_d   = 1'b0;
    ld_out  = 1'b0;
    ld_hold = 1'b0;
    have_d  = have_q;
    i_d     = out_i;
    q_d     = out_q;
    hold_d  = hold_q;
    if (cap_vld) begin
      if (!cfg_interleave) begin
        ld_out = 1'b1;
        i_d    = word_a;
        q_d    = word_b;
        have_d = 1'b0;
      end else if (tag_is_i) begin
        ld_hold = 1'b1;
        hold_d  = word_a;
        have_d  = 1'b1;
      end else if (have_q) begin
        ld_out = 1'b1;
        i_d    = hold_q;
        q_d    = word_a;
        have_d = 1'b0;
      end
    end
    vld_d = ld_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_i     <= '0;
      out_q     <= '0;
      out_valid <= 1'b0;
      hold_q    <= '0;
      have_q    <= 1'b0;
    end else begin
      out_valid <= vld_d;
      have_q    <= have_d;
      if (ld_out) begin
        out_i <= i_d;
        out_q <= q_d;
      end
      if (ld_hold) hold_q <= hold_d;
    end
  end

  // R1
  dual_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_vld && !cfg_interleave) |=>
      (out_valid && out_i == $past(word_a) && out_q == $past(word_b)));
  // R3
  pair_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_vld && cfg_interleave && !tag_is_i && have_q) |=>
      (out_valid && out_i == $past(hold_q) && !have_q));
  // R4
  i_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_vld && cfg_interleave && tag_is_i) |=>
      (have_q && hold_q == $past(word_a) && !out_valid));
  // R5
  lone_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_vld && cfg_interleave && !tag_is_i && !have_q) |=> !out_valid);
  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_i) && $stable(out_q)));
  // R9
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_i == '0 && out_q == '0));
endmodule

// File: rtl/iq_port_demux.sv
module iq_port_demux
  import iq_demux_pkg::*;
#(
  parameter int DW = IQ_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_interleave,
  input  logic          cfg_fall_edge,
  input  logic          cfg_offset_bin,
  input  logic [DW-1:0] lane_a,
  input  logic [DW-3:0] lane_b,
  input  logic          tag_pin,
  input  logic          alt_pin,
  output logic [DW-1:0] out_i,
  output logic [DW-1:0] out_q,
  output logic          out_valid
);
  localparam int PW = IQ_LANES * DW;

  logic [1:0]    rst_sync;
  logic          rst_int_n;
  logic [PW-1:0] pins;
  logic [PW-1:0] cap_word;
  logic          cap_vld;
  logic [PW-1:0] conv_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign pins = {tag_pin, alt_pin, lane_b, lane_a};

  iq_edge_capture #(.W(PW)) u_cap (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .cfg_fall_edge (cfg_fall_edge),
    .pins          (pins),
    .cap_word      (cap_word),
    .cap_vld       (cap_vld)
  );

  for (genvar g = 0; g < IQ_LANES; g++) begin : g_lane
    iq_fmt_lane #(.DW(DW)) u_fmt (
      .cfg_offset_bin (cfg_offset_bin),
      .din            (cap_word[g*DW +: DW]),
      .dout           (conv_word[g*DW +: DW])
    );
  end

  iq_pair_assembler #(.DW(DW)) u_asm (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .cfg_interleave (cfg_interleave),
    .cap_vld        (cap_vld),
    .tag_is_i       (cap_word[PW-1]),
    .word_a         (conv_word[LANE_I*DW +: DW]),
    .word_b         (conv_word[LANE_Q*DW +: DW]),
    .out_i          (out_i),
    .out_q          (out_q),
    .out_valid      (out_valid)
  );
endmodule

// File: tb/iq_port_demux_tb_top.sv
`timescale 1ns/100ps
module iq_port_demux_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_interleave, cfg_fall_edge, cfg_offset_bin;
  logic [11:0] lane_a;
  logic [9:0]  lane_b;
  logic        tag_pin, alt_pin;
  logic [11:0] out_i, out_q;
  logic        out_valid;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  iq_port_demux dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_interleave(cfg_interleave), .cfg_fall_edge(cfg_fall_edge),
    .cfg_offset_bin(cfg_offset_bin),
    .lane_a(lane_a), .lane_b(lane_b), .tag_pin(tag_pin), .alt_pin(alt_pin),
    .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
  );

  // expectation pipeline, two iterations deep
  logic        e_chk[2], e_v[2];
  logic [11:0] e_i[2], e_q[2];
  string       e_tag[2];
  logic [11:0] last_i, last_q, m_hold;
  logic        m_have, m_over;

  function automatic logic [11:0] conv(input logic [11:0] x);
    return cfg_offset_bin ? (x ^ 12'h800) : x;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual v/i/q=%h expected %h (mode=%0b edge=%0b fmt=%0b)",
               tag, act, exp, cfg_interleave, cfg_fall_edge, cfg_offset_bin);
    end
  endtask

  task automatic drive(input logic [23:0] w);
    {tag_pin, alt_pin, lane_b, lane_a} = w;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive('0);
    repeat (3) begin
      @(posedge clk); #0.5;
      check(out_valid == 1'b0 && out_i == '0 && out_q == '0, "R9 reset",
            {out_valid, out_i, out_q, 11'd0}, 36'd0);
    end
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    last_i = '0; last_q = '0; m_have = 1'b0; m_over = 1'b0; m_hold = '0;
    for (int k = 0; k < 2; k++) e_chk[k] = 1'b0;
  endtask

  task automatic step(input logic [11:0] a, input logic [9:0] b, input logic sel, input logic alt);
    logic [23:0] w;
    logic        v;
    logic [11:0] xi, xq;
    string       tg;
    w = {sel, alt, b, a};
    @(posedge clk); #0.5;
    if (e_chk[1]) begin
      if (e_v[1]) begin
        check(out_valid && out_i == e_i[1] && out_q == e_q[1], e_tag[1],
              {3'd0, out_valid, out_i, out_q}, {3'd0, 1'b1, e_i[1], e_q[1]});
        last_i = e_i[1]; last_q = e_q[1];
      end else begin
        check(!out_valid && out_i == last_i && out_q == last_q, {e_tag[1], " R8"},
              {3'd0, out_valid, out_i, out_q}, {4'd0, last_i, last_q});
      end
    end
    #0.5;
    drive(cfg_fall_edge ? w : ~w);
    @(negedge clk); #1;
    drive(cfg_fall_edge ? ~w : w);
    // model from requirements
    v = 1'b0; xi = '0; xq = '0;
    if (!cfg_interleave) begin
      v = 1'b1; xi = conv(a); xq = conv({sel, alt, b}); tg = "R1 R6 R7";
    end else if (sel) begin
      tg = m_have ? "R4 R2" : "R2";
      m_over = m_have; m_hold = conv(a); m_have = 1'b1;
    end else if (m_have) begin
      v = 1'b1; xi = m_hold; xq = conv(a); m_have = 1'b0;
      tg = m_over ? "R4 R3 R6 R7" : "R3 R2 R6 R7";
    end else begin
      tg = "R5";
    end
    e_chk[1] = e_chk[0]; e_v[1] = e_v[0]; e_i[1] = e_i[0]; e_q[1] = e_q[0]; e_tag[1] = e_tag[0];
    e_chk[0] = 1'b1; e_v[0] = v; e_i[0] = xi; e_q[0] = xq; e_tag[0] = tg;
  endtask

  task automatic flush();
    // trailing Q words carry no held I after the first, so they drain the pipe
    for (int k = 0; k < 2; k++) step(12'h000, 10'h000, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_interleave = 1'b0; cfg_fall_edge = 1'b0; cfg_offset_bin = 1'b0;
    drive('0);
    fork
      begin
        for (int c = 0; c < 4; c++) begin
          cfg_interleave = 1'b0; cfg_fall_edge = c[0]; cfg_offset_bin = c[1];
          do_reset();
          for (int k = 0; k < 4096; k++)
            step(12'((k * 1237 + c * 11) & 12'hfff), 10'((k * 389 + 77) & 10'h3ff),
                 1'((k >> 3) & 1), 1'((k >> 5) & 1));
          flush();
        end
        for (int c = 0; c < 4; c++) begin
          cfg_interleave = 1'b1; cfg_fall_edge = c[0]; cfg_offset_bin = c[1];
          do_reset();
          for (int k = 0; k < 1024; k++)
            step(12'((k * 2741 + 5) & 12'hfff), 10'((k * 97) & 10'h3ff),
                 1'((k % 3 == 0) || (k % 7 == 2)), 1'(k & 1));
          flush();
        end
      end
      begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule